// File: doc/BRIEF.md
# Bit-Addressed Interrupt Status Register

This block holds an eight-bit status byte for an I/O controller card. Each bit belongs to one address of an eight-address window on the local processor's I/O bus. Hardware events raise the bits. A read or a write by the local processor to a bit's own address lowers that bit again, so an interrupt service routine acknowledges its source with a single access and touches no other bit.

The four lowest bits track local interrupt sources and appear on the active-high `local_irq` outputs. Bit 6 records that the local processor was held off main memory. Its clear is refused while the arbitration logic reports a pending dummy read. Bit 7 is an active-low request to the host CPU and is driven out directly as `host_irq_n`. Firmware pulls it low with a set strobe, and an access to offset 7 returns it to 1, the acknowledged state. Bits 5 and 4 are not implemented.

Each implemented bit is a two-state flag machine with the states FLAG_IDLE and FLAG_RAISED. The transition RAISE (FLAG_IDLE to FLAG_RAISED) is taken on a set event. The transition DROP (FLAG_RAISED to FLAG_IDLE) is taken on a clearing access when there is no set event and no hold on that bit. Otherwise each state remains as it is (STAY). Bit 7 stores the request as FLAG_RAISED = pending and is inverted on output.

Top module: `bit_status_reg`

## Requirements
- R1: After reset, `status` is 8'h80, `local_irq` is 0 and `host_irq_n` is 1.
- R2: A read (`loc_rd`) or a write (`loc_wr`) at address WIN_BASE+k, for k in 0..3, clears status bit k from the next clock edge on and leaves all other bits unchanged.
- R3: An access to an address outside WIN_BASE..WIN_BASE+7 changes no bit. The window is the aligned eight-address block selected by the address bits above bit 2.
- R4: Set events act on the next edge and the bit holds until it is cleared: `idvec_acc` sets bit 0, `host_attn_evt` sets bit 1, `scc_evt` sets bit 2, `dma_evt` sets bit 3, `bus_delay_evt` sets bit 6, and `host_req_set` drives bit 7 to 0.
- R5: When a set event and a clearing access to the same bit fall in the same cycle, the set wins.
- R6: An access to offset 6 clears bit 6, unless `dummy_rd_pend` is 1 in that cycle. In that case bit 6 stays 1.
- R7: An access to offset 7 drives bit 7 to 1, and `host_irq_n` always equals status bit 7.
- R8: `idvec_acc` does not set bit 0 while `intack` is 1.
- R9: Status bits 5 and 4 always read 0, and accesses to offsets 4 and 5 change nothing.
- R10: `local_irq[3:0]` always equals status bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| loc_rd | input | 1 | Local processor read strobe, one cycle |
| loc_wr | input | 1 | Local processor write strobe, one cycle |
| loc_addr | input | ADDR_W | Local processor I/O address |
| dma_evt | input | 1 | DMA controller interrupt event |
| scc_evt | input | 1 | Serial controller interrupt event |
| host_attn_evt | input | 1 | Host CPU access to this register (attention) |
| idvec_acc | input | 1 | Access to the ID/vector register |
| intack | input | 1 | Current cycle is an interrupt acknowledge |
| bus_delay_evt | input | 1 | Local main-memory access was delayed |
| dummy_rd_pend | input | 1 | Dummy read pending; blocks clearing of bit 6 |
| host_req_set | input | 1 | Firmware strobe raising the host request |
| status | output | 8 | Status byte |
| local_irq | output | 4 | Active-high local interrupts (bits 3..0) |
| host_irq_n | output | 1 | Active-low host interrupt request |

## Verification
The bench builds the block with its defaults, ADDR_W = 16 and WIN_BASE = 16'h0488. It sweeps every address from eight below the window to eight above it, with reads and writes and with `dummy_rd_pend` both low and high. This covers every offset inside the window and the neighbours on both sides. Each bit is also driven with a set and a clear in the same cycle, and the interrupt-acknowledge suppression of bit 0 is tested.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int NBITS = 8;
    localparam int OFS_W = $clog2(NBITS);
    // bits that hold state; 5 and 4 are absent
    localparam logic [NBITS-1:0] USED_MASK = 8'b1100_1111;
    // bits stored active-high but presented inverted
    localparam logic [NBITS-1:0] INVERT_MASK = 8'b1000_0000;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;
endpackage

// File: rtl/isr_window_decode.sv
module isr_window_decode
    import isr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0488
) (
    input  logic              access,
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  hit
);
    always_comb begin
        hit = '0;
        if (access && (addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W])) begin
            hit[addr[OFS_W-1:0]] = 1'b1;
        end
    end
endmodule

// File: rtl/isr_event_map.sv
module isr_event_map
    import isr_pkg::*;
(
    input  logic             dma_evt,
    input  logic             scc_evt,
    input  logic             host_attn_evt,
    input  logic             idvec_acc,
    input  logic             intack,
    input  logic             bus_delay_evt,
    input  logic             dummy_rd_pend,
    input  logic             host_req_set,
    output logic [NBITS-1:0] set_vec,
    output logic [NBITS-1:0] hold_vec
);
    always_comb begin
        set_vec    = '0;
        set_vec[0] = idvec_acc & ~intack;
        set_vec[1] = host_attn_evt;
        set_vec[2] = scc_evt;
        set_vec[3] = dma_evt;
        set_vec[6] = bus_delay_evt;
        set_vec[7] = host_req_set;
        hold_vec    = '0;
        hold_vec[6] = dummy_rd_pend;
    end
endmodule

// File: rtl/isr_flag_cell.sv
module isr_flag_cell
    import isr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic hold_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (set_i) state_d = FLAG_RAISED;
            FLAG_RAISED: if (clr_i && !hold_i && !set_i) state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLAG_RAISED);
    end
endmodule

// File: rtl/bit_status_reg.sv
module bit_status_reg
    import isr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0488
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_rd,
    input  logic              loc_wr,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              dma_evt,
    input  logic              scc_evt,
    input  logic              host_attn_evt,
    input  logic              idvec_acc,
    input  logic              intack,
    input  logic              bus_delay_evt,
    input  logic              dummy_rd_pend,
    input  logic              host_req_set,
    output logic [7:0]        status,
    output logic [3:0]        local_irq,
    output logic              host_irq_n
);
    logic [NBITS-1:0] hit;
    logic [NBITS-1:0] set_vec;
    logic [NBITS-1:0] hold_vec;
    logic [NBITS-1:0] flags;

    isr_window_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
        .access (loc_rd | loc_wr),
        .addr   (loc_addr),
        .hit    (hit)
    );

    isr_event_map u_map (
        .dma_evt       (dma_evt),
        .scc_evt       (scc_evt),
        .host_attn_evt (host_attn_evt),
        .idvec_acc     (idvec_acc),
        .intack        (intack),
        .bus_delay_evt (bus_delay_evt),
        .dummy_rd_pend (dummy_rd_pend),
        .host_req_set  (host_req_set),
        .set_vec       (set_vec),
        .hold_vec      (hold_vec)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (USED_MASK[i]) begin : g_cell
            isr_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[i]),
                .clr_i  (hit[i]),
                .hold_i (hold_vec[i]),
                .flag_o (flags[i])
            );
        end else begin : g_absent
            logic unused_sink;
            assign unused_sink = hit[i] | set_vec[i] | hold_vec[i];
            assign flags[i]    = 1'b0;
        end
    end

    always_comb begin
        status     = flags ^ INVERT_MASK;
        local_irq  = status[3:0];
        host_irq_n = status[7];
    end
endmodule

// File: rtl/isr_checker.sv
module isr_checker #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0488
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loc_rd,
    input logic              loc_wr,
    input logic [ADDR_W-1:0] loc_addr,
    input logic              dma_evt,
    input logic              scc_evt,
    input logic              host_attn_evt,
    input logic              idvec_acc,
    input logic              intack,
    input logic              bus_delay_evt,
    input logic              dummy_rd_pend,
    input logic              host_req_set,
    input logic [7:0]        status,
    input logic [3:0]        local_irq,
    input logic              host_irq_n
);
    logic acc, in_win, any_evt;
    logic [2:0] ofs;
    assign acc     = loc_rd | loc_wr;
    assign in_win  = acc && (loc_addr[ADDR_W-1:3] == WIN_BASE[ADDR_W-1:3]);
    assign ofs     = loc_addr[2:0];
    assign any_evt = dma_evt | scc_evt | host_attn_evt | idvec_acc |
                     bus_delay_evt | host_req_set;

    assert_absent_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:4] == 2'b00);
    assert_irq_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        local_irq == status[3:0]);
    assert_host_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_n == status[7]);
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && dummy_rd_pend) |=> status[6]);
    assert_dma_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_evt |=> status[3]);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && ofs == 3'd7 && host_req_set) |=> !status[7]);
    assert_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_win && !any_evt) |=> $stable(status));
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && ofs == 3'd3 && !dma_evt) |=> !status[3]);
    assert_intack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && idvec_acc && intack) |=> !status[0]);
endmodule

bind bit_status_reg isr_checker #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (.*);

// File: tb/sim_bit_status_reg.sv
module sim_bit_status_reg;
    localparam int AW = 16;
    localparam logic [AW-1:0] BASE = 16'h0488;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_rd = 0, loc_wr = 0;
    logic [AW-1:0] loc_addr = '0;
    logic dma_evt = 0, scc_evt = 0, host_attn_evt = 0, idvec_acc = 0, intack = 0;
    logic bus_delay_evt = 0, dummy_rd_pend = 0, host_req_set = 0;
    logic [7:0] status;
    logic [3:0] local_irq;
    logic host_irq_n;

    int n_tests = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bit_status_reg #(.ADDR_W(AW), .WIN_BASE(BASE)) u0 (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet();
        loc_rd = 0; loc_wr = 0; dma_evt = 0; scc_evt = 0; host_attn_evt = 0;
        idvec_acc = 0; intack = 0; bus_delay_evt = 0; dummy_rd_pend = 0; host_req_set = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic raise_all();
        dma_evt = 1; scc_evt = 1; host_attn_evt = 1; idvec_acc = 1;
        bus_delay_evt = 1; host_req_set = 1;
        tick();
        quiet();
    endtask

    task automatic access(input logic [AW-1:0] a, input bit wr);
        loc_addr = a;
        if (wr) loc_wr = 1; else loc_rd = 1;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 8; k++) begin
            access(BASE + AW'(k), k[0]);
            tick();
            quiet();
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 status", status, 8'h80);
        check("R1 local_irq", {4'h0, local_irq}, 8'h00);
        check("R1 host_irq_n", {7'h0, host_irq_n}, 8'h01);

        // sweep addresses around the window, read/write, dummy read
        for (int a = -8; a < 16; a++) begin
            for (int rw = 0; rw < 2; rw++) begin
                for (int dp = 0; dp < 2; dp++) begin
                    logic [7:0] exp;
                    string tag;
                    raise_all();
                    check("R4 all set", status, 8'h4F);
                    exp = 8'h4F;
                    tag = "R3 outside";
                    if (a >= 0 && a < 8) begin
                        if (a == 7) begin exp[7] = 1'b1; tag = "R7 offset7"; end
                        else if (a == 6) begin
                            if (dp == 0) exp[6] = 1'b0;
                            tag = "R6 offset6";
                        end
                        else if (a >= 4) tag = "R9 offset4_5";
                        else begin exp[a] = 1'b0; tag = "R2 clear"; end
                    end
                    access(BASE + AW'(a), rw[0]);
                    dummy_rd_pend = dp[0];
                    tick();
                    quiet();
                    check(tag, status, exp);
                    check("R10 local_irq", {4'h0, local_irq}, {4'h0, exp[3:0]});
                    check("R7 host_irq_n", {7'h0, host_irq_n}, {7'h0, exp[7]});
                    clear_all();
                    check("R2 cleared", status, 8'h80);
                end
            end
        end

        // set beats clear in the same cycle, per implemented bit
        for (int k = 0; k < 8; k++) begin
            logic [7:0] exp;
            if (k == 4 || k == 5) continue;
            access(BASE + AW'(k), 1'b0);
            case (k)
                0: idvec_acc = 1;
                1: host_attn_evt = 1;
                2: scc_evt = 1;
                3: dma_evt = 1;
                6: bus_delay_evt = 1;
                default: host_req_set = 1;
            endcase
            tick();
            quiet();
            exp = 8'h80;
            if (k == 7) exp[7] = 1'b0; else exp[k] = 1'b1;
            check("R5 set wins", status, exp);
            clear_all();
        end

        // interrupt acknowledge suppresses bit 0
        idvec_acc = 1; intack = 1;
        tick();
        quiet();
        check("R8 intack", status, 8'h80);
        idvec_acc = 1;
        tick();
        quiet();
        check("R8 no intack", status, 8'h81);
        check("R10 bit0", {4'h0, local_irq}, 8'h01);
        // single event holds until cleared
        tick();
        check("R4 hold", status, 8'h81);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule